// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs one complete raw NAND operation from a handful of register writes. Software first loads the address bytes, the transfer length and an optional closing command byte. It then writes a control word that carries the opening opcode, the direction of any data phase, the number of address cycles and which of two chip enables to use. Setting the start bit in that write launches the operation. From there the sequencer drives the 8-bit flash bus by itself. It issues a command latch cycle, then the address latch cycles, then any program data taken from a byte stream, then the closing command. After that it waits a fixed settle time, waits for the ready/busy line to report ready, and for reads hands the fetched bytes out on a second byte stream.

Completion is signalled through two sticky interrupt bits. One marks the end of any operation. The other marks the end of a read transfer, and a read is complete only once it is set. Each bit is cleared by writing a one to its position. A soft-reset bit aborts whatever is running and clears both bits. Bus pulse widths and the settle time are parameters counted in clock cycles.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, both chip enables are high, the command and address latches are low, both strobes are high and both interrupt bits are low.
- R2: A write to register 0 with bit 31 set starts an operation. Its first bus cycle is a command latch carrying bits 7:0 of that word.
- R3: When bit 30 of the start word is set, exactly (bits 29:27)+1 address latch cycles follow the command. They send register 2 bits 7:0, then register 2 bits 15:8, then register 3 bytes from low to high.
- R4: When bit 25 of the start word is set, register 4 value + 1 bytes are taken from the transmit stream and written to the bus in stream order, with both latches low.
- R5: When register 1 bit 8 is set, a second command latch carrying register 1 bits 7:0 is issued. It follows the data phase for writes and the address phase otherwise. When bit 8 is clear, no second command is issued.
- R6: After the last latch cycle the block waits for the ready/busy input to be high. The done bit is not set while that input is low.
- R7: When bit 26 of the start word is set, register 4 value + 1 bytes are read from the bus after ready. They are presented in order on the receive stream, and each byte is held until accepted.
- R8: Completion sets the done flag, and a read also sets the transfer flag. Writing register 5 with bit 31 or bit 28 clears the done or transfer flag respectively. A set in the same cycle as a clear wins.
- R9: A start word with bit 26 set and bit 30 clear is refused: no bus activity and no interrupt.
- R10: Writing register 6 with bit 0 set returns the block to idle, releases the chip enables and clears both interrupt bits. The next operation then runs normally.
- R11: During an operation, bit 19 of the start word selects chip enable 1 (low) instead of chip enable 0. At most one chip enable is ever low.
- R12: A start written while an operation is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| tx_data | input | 8 | Program byte stream data |
| tx_valid | input | 1 | Program byte available |
| tx_ready | output | 1 | Program byte taken |
| rx_data | output | 8 | Read byte stream data |
| rx_valid | output | 1 | Read byte available |
| rx_ready | input | 1 | Read byte accepted |
| nf_ce_n | output | 2 | Chip enables, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Bus data driven to flash |
| nf_dq_oe | output | 1 | Bus drive enable |
| nf_dq_in | input | 8 | Bus data from flash |
| nf_rb | input | 1 | Ready (high) / busy (low) |
| irq_cmd_done | output | 1 | Sticky operation-done flag |
| irq_xfer_done | output | 1 | Sticky read-transfer-done flag |
| irq | output | 1 | OR of the two flags |

## Verification
The completion event that sets the done flag can land in the same clock as a software write that clears it. The bench provokes this by writing a clear of the done bit in every cycle while an erase runs to completion, so that one of those writes is certain to meet the set event. If the set takes priority, the flag must be seen high for exactly one cycle before the following clear removes it. If the clear took priority, the completion would never be seen at all.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
   localparam logic [2:0] REG_START  = 3'd0;
   localparam logic [2:0] REG_CMD2   = 3'd1;
   localparam logic [2:0] REG_ADDR_L = 3'd2;
   localparam logic [2:0] REG_ADDR_H = 3'd3;
   localparam logic [2:0] REG_LEN    = 3'd4;
   localparam logic [2:0] REG_IRQ    = 3'd5;
   localparam logic [2:0] REG_SRST   = 3'd6;

   localparam int B_GO      = 31;
   localparam int B_ADDR_EN = 30;
   localparam int B_RD      = 26;
   localparam int B_WR      = 25;
   localparam int B_CE      = 19;
   localparam int B_C2_EN   = 8;
   localparam int B_IRQ_DN  = 31;
   localparam int B_IRQ_XF  = 28;

   typedef enum logic [3:0] {
      S_IDLE, S_CMD1, S_ADDR, S_WLOAD, S_WDATA, S_CMD2,
      S_TWB, S_WAITRB, S_RDATA, S_RHOLD, S_FINISH
   } seq_state_t;

   typedef struct packed {
      logic [7:0] opcode;
      logic       rd;
      logic       wr;
      logic       addr_en;
      logic [2:0] addr_m1;
      logic       ce_sel;
   } op_cfg_t;
endpackage

// File: rtl/nfs_regs.sv
module nfs_regs
   import nfs_pkg::*;
#(
   parameter int LEN_W     = 12,
   parameter int ADDR_HI_W = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [2:0]           wr_addr,
   input  logic [31:0]          wr_data,
   input  logic                 evt_done,
   input  logic                 evt_xfer,
   output logic                 start,
   output op_cfg_t              start_cfg,
   output logic                 cmd2_en,
   output logic [7:0]           cmd2_byte,
   output logic [15:0]          addr_lo,
   output logic [ADDR_HI_W-1:0] addr_hi,
   output logic [LEN_W-1:0]     xfer_len,
   output logic                 soft_rst,
   output logic                 irq_done,
   output logic                 irq_xfer
);
   logic unused_wdata;
   logic clr_done, clr_xfer;

   assign unused_wdata = ^wr_data;

   assign start    = wr_en && (wr_addr == REG_START) && wr_data[B_GO];
   assign soft_rst = wr_en && (wr_addr == REG_SRST) && wr_data[0];
   assign clr_done = wr_en && (wr_addr == REG_IRQ) && wr_data[B_IRQ_DN];
   assign clr_xfer = wr_en && (wr_addr == REG_IRQ) && wr_data[B_IRQ_XF];

   always_comb begin
      start_cfg.opcode  = wr_data[7:0];
      start_cfg.rd      = wr_data[B_RD];
      start_cfg.wr      = wr_data[B_WR];
      start_cfg.addr_en = wr_data[B_ADDR_EN];
      start_cfg.addr_m1 = wr_data[29:27];
      start_cfg.ce_sel  = wr_data[B_CE];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd2_en   <= 1'b0;
         cmd2_byte <= '0;
         addr_lo   <= '0;
         addr_hi   <= '0;
         xfer_len  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            REG_CMD2: begin
               cmd2_en   <= wr_data[B_C2_EN];
               cmd2_byte <= wr_data[7:0];
            end
            REG_ADDR_L: addr_lo  <= wr_data[15:0];
            REG_ADDR_H: addr_hi  <= wr_data[ADDR_HI_W-1:0];
            REG_LEN:    xfer_len <= wr_data[LEN_W-1:0];
            default: ;
         endcase
      end
   end

   // sticky flags: soft reset first, then set beats clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_done <= 1'b0;
         irq_xfer <= 1'b0;
      end else if (soft_rst) begin
         irq_done <= 1'b0;
         irq_xfer <= 1'b0;
      end else begin
         if (evt_done)      irq_done <= 1'b1;
         else if (clr_done) irq_done <= 1'b0;
         if (evt_xfer)      irq_xfer <= 1'b1;
         else if (clr_xfer) irq_xfer <= 1'b0;
      end
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done && !soft_rst |=> irq_done); // R8
   AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !irq_done && !irq_xfer); // R10
endmodule

// File: rtl/nfs_strobe.sv
module nfs_strobe #(
   parameter int LO = 2,
   parameter int HI = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic strobe_n,
   output logic sample,
   output logic last
);
   localparam int CW = $clog2(LO + HI + 1);
   localparam logic [CW-1:0] C_LO   = CW'(LO);
   localparam logic [CW-1:0] C_SAMP = CW'(LO - 1);
   localparam logic [CW-1:0] C_END  = CW'(LO + HI - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run || last) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign strobe_n = !(run && (cnt < C_LO));
   assign sample   = run && (cnt == C_SAMP);
   assign last     = run && (cnt == C_END);
endmodule

// File: rtl/nfs_seq.sv
module nfs_seq
   import nfs_pkg::*;
#(
   parameter int LEN_W     = 12,
   parameter int ADDR_HI_W = 24,
   parameter int TWB_CYC   = 4,
   parameter int RB_SYNC   = 2,
   parameter int PULSE_LO  = 2,
   parameter int PULSE_HI  = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  op_cfg_t              start_cfg,
   input  logic                 cmd2_en,
   input  logic [7:0]           cmd2_byte,
   input  logic [15:0]          addr_lo,
   input  logic [ADDR_HI_W-1:0] addr_hi,
   input  logic [LEN_W-1:0]     xfer_len,
   input  logic                 soft_rst,
   input  logic [7:0]           tx_data,
   input  logic                 tx_valid,
   output logic                 tx_ready,
   output logic [7:0]           rx_data,
   output logic                 rx_valid,
   input  logic                 rx_ready,
   output logic [1:0]           nf_ce_n,
   output logic                 nf_cle,
   output logic                 nf_ale,
   output logic                 nf_we_n,
   output logic                 nf_re_n,
   output logic [7:0]           nf_dq_out,
   output logic                 nf_dq_oe,
   input  logic [7:0]           nf_dq_in,
   input  logic                 nf_rb,
   output logic                 evt_done,
   output logic                 evt_xfer
);
   localparam int NB  = 2 + ADDR_HI_W / 8;
   localparam int TCW = $clog2(TWB_CYC + 1);
   localparam logic [TCW-1:0] TWB_END = TCW'(TWB_CYC - 1);

   seq_state_t state, nxt;
   op_cfg_t    cfg;
   logic [2:0]       acnt;
   logic [LEN_W-1:0] dcnt;
   logic [TCW-1:0]   tcnt;
   logic [7:0]       wbyte, rbyte, addr_byte;
   logic             rb_s, run, stb_n, stb_sample, stb_last, accept;
   logic [7:0]       abyte [NB];

   // address byte lanes: low register first, then high register
   for (genvar g = 0; g < NB; g++) begin : g_abyte
      if (g < 2) begin : g_lo
         assign abyte[g] = addr_lo[8*g +: 8];
      end else begin : g_hi
         assign abyte[g] = addr_hi[8*(g-2) +: 8];
      end
   end

   always_comb begin
      addr_byte = 8'h00;
      for (int i = 0; i < NB; i++)
         if (acnt == 3'(i)) addr_byte = abyte[i];
   end

   // ready/busy synchroniser variant
   if (RB_SYNC == 0) begin : g_rb_direct
      assign rb_s = nf_rb;
   end else begin : g_rb_sync
      logic [RB_SYNC-1:0] rb_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rb_q <= '0;
         else        rb_q <= {rb_q[RB_SYNC-2:0], nf_rb};
      end
      assign rb_s = rb_q[RB_SYNC-1];
   end

   assign run = (state == S_CMD1) || (state == S_ADDR) || (state == S_WDATA) ||
                (state == S_CMD2) || (state == S_RDATA);

   nfs_strobe #(.LO(PULSE_LO), .HI(PULSE_HI)) u_strobe (
      .clk(clk), .rst_n(rst_n), .run(run),
      .strobe_n(stb_n), .sample(stb_sample), .last(stb_last)
   );

   assign accept = start && (state == S_IDLE) && !(start_cfg.rd && !start_cfg.addr_en);

   function automatic seq_state_t after_addr(input op_cfg_t c, input logic c2);
      if (c.wr)    return S_WLOAD;
      else if (c2) return S_CMD2;
      else         return S_TWB;
   endfunction

   always_comb begin
      nxt = state;
      case (state)
         S_IDLE:   if (accept) nxt = S_CMD1;
         S_CMD1:   if (stb_last) nxt = cfg.addr_en ? S_ADDR : after_addr(cfg, cmd2_en);
         S_ADDR:   if (stb_last && acnt == cfg.addr_m1) nxt = after_addr(cfg, cmd2_en);
         S_WLOAD:  if (tx_valid) nxt = S_WDATA;
         S_WDATA:  if (stb_last) nxt = (dcnt == xfer_len) ? (cmd2_en ? S_CMD2 : S_TWB) : S_WLOAD;
         S_CMD2:   if (stb_last) nxt = S_TWB;
         S_TWB:    if (tcnt == TWB_END) nxt = S_WAITRB;
         S_WAITRB: if (rb_s) nxt = cfg.rd ? S_RDATA : S_FINISH;
         S_RDATA:  if (stb_last) nxt = S_RHOLD;
         S_RHOLD:  if (rx_ready) nxt = (dcnt == xfer_len) ? S_FINISH : S_RDATA;
         S_FINISH: nxt = S_IDLE;
         default:  nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         cfg   <= '0;
         acnt  <= '0;
         dcnt  <= '0;
         tcnt  <= '0;
         wbyte <= '0;
         rbyte <= '0;
      end else if (soft_rst) begin
         state <= S_IDLE;
         acnt  <= '0;
         dcnt  <= '0;
         tcnt  <= '0;
      end else begin
         state <= nxt;
         if (accept) cfg <= start_cfg;
         if (state == S_IDLE) begin
            acnt <= '0;
            dcnt <= '0;
         end
         if (state == S_ADDR && stb_last) acnt <= acnt + 1'b1;
         if (state == S_WLOAD && tx_valid) wbyte <= tx_data;
         if (state == S_WDATA && stb_last) dcnt <= dcnt + 1'b1;
         if (state == S_RDATA && stb_sample) rbyte <= nf_dq_in;
         if (state == S_RHOLD && rx_ready) dcnt <= dcnt + 1'b1;
         tcnt <= (state == S_TWB) ? tcnt + 1'b1 : '0;
      end
   end

   assign tx_ready = (state == S_WLOAD);
   assign rx_valid = (state == S_RHOLD);
   assign rx_data  = rbyte;
   assign nf_cle   = (state == S_CMD1) || (state == S_CMD2);
   assign nf_ale   = (state == S_ADDR);
   assign nf_we_n  = (state == S_RDATA) ? 1'b1 : stb_n;
   assign nf_re_n  = (state == S_RDATA) ? stb_n : 1'b1;
   assign nf_dq_oe = nf_cle || nf_ale || (state == S_WDATA);
   assign nf_ce_n  = (state == S_IDLE) ? 2'b11 : (cfg.ce_sel ? 2'b01 : 2'b10);
   assign evt_done = (state == S_FINISH);
   assign evt_xfer = (state == S_FINISH) && cfg.rd;

   always_comb begin
      case (state)
         S_CMD1:  nf_dq_out = cfg.opcode;
         S_CMD2:  nf_dq_out = cmd2_byte;
         S_ADDR:  nf_dq_out = addr_byte;
         S_WDATA: nf_dq_out = wbyte;
         default: nf_dq_out = 8'h00;
      endcase
   end

   AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_IDLE |-> nf_we_n && nf_re_n && !nf_cle && !nf_ale); // R1
   AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~nf_ce_n)); // R11
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nf_we_n && !nf_re_n)); // R4
   AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      nf_ale |-> acnt <= cfg.addr_m1); // R3
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R7
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
   import nfs_pkg::*;
#(
   parameter int LEN_W     = 12,
   parameter int ADDR_HI_W = 24,
   parameter int TWB_CYC   = 4,
   parameter int RB_SYNC   = 2,
   parameter int PULSE_LO  = 2,
   parameter int PULSE_HI  = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   input  logic [7:0]  tx_data,
   input  logic        tx_valid,
   output logic        tx_ready,
   output logic [7:0]  rx_data,
   output logic        rx_valid,
   input  logic        rx_ready,
   output logic [1:0]  nf_ce_n,
   output logic        nf_cle,
   output logic        nf_ale,
   output logic        nf_we_n,
   output logic        nf_re_n,
   output logic [7:0]  nf_dq_out,
   output logic        nf_dq_oe,
   input  logic [7:0]  nf_dq_in,
   input  logic        nf_rb,
   output logic        irq_cmd_done,
   output logic        irq_xfer_done,
   output logic        irq
);
   if (PULSE_LO < 1 || PULSE_HI < 1) begin : g_bad_pulse
      $error("pulse phases need at least one cycle each");
   end
   if (TWB_CYC < 1) begin : g_bad_twb
      $error("settle count must be at least one");
   end
   if (RB_SYNC == 1 || RB_SYNC < 0) begin : g_bad_sync
      $error("ready/busy sync must be zero or two or more stages");
   end
   if (ADDR_HI_W % 8 != 0 || ADDR_HI_W < 8 || ADDR_HI_W > 48) begin : g_bad_addr
      $error("high address width must be whole bytes, 8 to 48");
   end
   if (LEN_W < 1 || LEN_W > 24) begin : g_bad_len
      $error("length width out of range");
   end

   op_cfg_t                start_cfg;
   logic                   start, cmd2_en, soft_rst, evt_done, evt_xfer;
   logic [7:0]             cmd2_byte;
   logic [15:0]            addr_lo;
   logic [ADDR_HI_W-1:0]   addr_hi;
   logic [LEN_W-1:0]       xfer_len;

   nfs_regs #(.LEN_W(LEN_W), .ADDR_HI_W(ADDR_HI_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_addr),
      .wr_data(reg_wdata), .evt_done(evt_done), .evt_xfer(evt_xfer),
      .start(start), .start_cfg(start_cfg), .cmd2_en(cmd2_en),
      .cmd2_byte(cmd2_byte), .addr_lo(addr_lo), .addr_hi(addr_hi),
      .xfer_len(xfer_len), .soft_rst(soft_rst),
      .irq_done(irq_cmd_done), .irq_xfer(irq_xfer_done)
   );

   nfs_seq #(
      .LEN_W(LEN_W), .ADDR_HI_W(ADDR_HI_W), .TWB_CYC(TWB_CYC),
      .RB_SYNC(RB_SYNC), .PULSE_LO(PULSE_LO), .PULSE_HI(PULSE_HI)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_cfg(start_cfg),
      .cmd2_en(cmd2_en), .cmd2_byte(cmd2_byte), .addr_lo(addr_lo),
      .addr_hi(addr_hi), .xfer_len(xfer_len), .soft_rst(soft_rst),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
      .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out),
      .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rb(nf_rb),
      .evt_done(evt_done), .evt_xfer(evt_xfer)
   );

   assign irq = irq_cmd_done || irq_xfer_done;
endmodule

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [7:0]  tx_data = '0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic [7:0]  rx_data;
   logic        rx_valid;
   logic        rx_ready = 1'b0;
   logic [1:0]  nf_ce_n;
   logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
   logic [7:0]  nf_dq_out;
   logic [7:0]  nf_dq_in = '0;
   logic        nf_rb = 1'b1;
   logic        irq_cmd_done, irq_xfer_done, irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // bus log captured at each write-strobe rising edge
   logic       log_cle [64];
   logic       log_ale [64];
   logic [7:0] log_dq  [64];
   logic [1:0] log_ce  [64];
   int         log_n = 0;
   logic [7:0] rx_buf [64];
   int         rx_n = 0;
   int         rd_idx = 0;
   int         tx_idx = 0;
   int         tx_cnt = 0;
   int         rx_mode = 0;
   int         cyc = 0;
   bit         cnt_en = 0;
   int         hi_cnt = 0;

   always #10 clk = ~clk;

   nand_cmd_seq u_nand_cmd_seq (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
      .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
      .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in),
      .nf_rb(nf_rb), .irq_cmd_done(irq_cmd_done),
      .irq_xfer_done(irq_xfer_done), .irq(irq)
   );

   function automatic logic [7:0] rd_pat(input int i);
      return 8'(8'hA0 + i * 3);
   endfunction

   always @(posedge nf_we_n) begin
      if (rst_n && log_n < 64) begin
         log_cle[log_n] = nf_cle;
         log_ale[log_n] = nf_ale;
         log_dq[log_n]  = nf_dq_out;
         log_ce[log_n]  = nf_ce_n;
         log_n++;
      end
   end

   always @(negedge nf_re_n) begin
      if (rst_n) begin
         nf_dq_in = rd_pat(rd_idx);
         rd_idx++;
      end
   end

   always @(posedge clk) begin
      if (rx_valid && rx_ready && rx_n < 64) begin
         rx_buf[rx_n] = rx_data;
         rx_n++;
      end
      if (tx_valid && tx_ready) tx_idx++;
   end

   always @(negedge clk) begin
      cyc++;
      tx_valid = (tx_idx < tx_cnt);
      tx_data  = 8'(8'h50 + tx_idx);
      rx_ready = (rx_mode == 0) ? 1'b1 : (rx_mode == 1) ? cyc[0] : 1'b0;
      if (cnt_en && irq_cmd_done) hi_cnt++;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_log(input string tag, input int i, input logic c, input logic a,
                          input logic [7:0] d);
      chk(tag, {23'd0, log_cle[i], log_ale[i], log_dq[i]}, {23'd0, c, a, d});
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic logic [31:0] ctl(input logic [7:0] op, input bit rd, input bit wrb,
                                       input int naddr, input bit ce);
      logic [31:0] v;
      v = 32'h8000_0000 | {24'd0, op};
      if (rd)  v[26] = 1'b1;
      if (wrb) v[25] = 1'b1;
      if (ce)  v[19] = 1'b1;
      if (naddr > 0) v[30:27] = 4'((naddr - 1) | 8);
      return v;
   endfunction

   task automatic prep();
      wr(3'd5, 32'h9000_0000);
      log_n = 0; rx_n = 0; rd_idx = 0; tx_idx = 0; tx_cnt = 0;
   endtask

   task automatic wait_done(input int limit);
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (irq_cmd_done) break;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 ce", {30'd0, nf_ce_n}, 32'd3);
      chk("R1 strobes/latches", {28'd0, nf_we_n, nf_re_n, nf_cle, nf_ale}, 32'hC);
      chk("R1 irq", {30'd0, irq_cmd_done, irq_xfer_done}, 32'd0);
   endtask

   task automatic t_program();
      prep();
      tx_cnt = 4;
      wr(3'd1, 32'h0000_0110);
      wr(3'd2, 32'h0000_1234);
      wr(3'd3, 32'h000A_0B0C);
      wr(3'd4, 32'd3);
      wr(3'd0, ctl(8'h80, 0, 1, 5, 0));
      wait_done(2000);
      chk("R2 done", {31'd0, irq_cmd_done}, 32'd1);
      chk("R8 no xfer on write", {31'd0, irq_xfer_done}, 32'd0);
      chk("R3/R4/R5 entry count", log_n, 32'd11);
      chk_log("R2 cmd1", 0, 1, 0, 8'h80);
      chk_log("R3 a0", 1, 0, 1, 8'h34);
      chk_log("R3 a1", 2, 0, 1, 8'h12);
      chk_log("R3 a2", 3, 0, 1, 8'h0C);
      chk_log("R3 a3", 4, 0, 1, 8'h0B);
      chk_log("R3 a4", 5, 0, 1, 8'h0A);
      for (int i = 0; i < 4; i++) chk_log("R4 data", 6 + i, 0, 0, 8'(8'h50 + i));
      chk_log("R5 cmd2 after data", 10, 1, 0, 8'h10);
      chk("R11 ce0", {30'd0, log_ce[0]}, 32'd2);
   endtask

   task automatic t_read_page();
      prep();
      rx_mode = 1;
      wr(3'd1, 32'h0000_0130);
      wr(3'd2, 32'h0000_0040);
      wr(3'd3, 32'h0000_0077);
      wr(3'd4, 32'd5);
      wr(3'd0, ctl(8'h00, 1, 0, 4, 1));
      wait_done(4000);
      rx_mode = 0;
      chk("R7 done", {30'd0, irq_cmd_done, irq_xfer_done}, 32'd3);
      chk("R5 entry count", log_n, 32'd6);
      chk_log("R2 cmd1 read", 0, 1, 0, 8'h00);
      chk_log("R3 a2 high reg", 3, 0, 1, 8'h77);
      chk_log("R5 cmd2 after addr", 5, 1, 0, 8'h30);
      chk("R11 ce1", {30'd0, log_ce[0]}, 32'd1);
      chk("R7 rx count", rx_n, 32'd6);
      for (int i = 0; i < 6; i++) chk("R7 rx byte", {24'd0, rx_buf[i]}, {24'd0, rd_pat(i)});
   endtask

   task automatic t_status();
      prep();
      wr(3'd1, 32'h0000_0000);
      wr(3'd2, 32'h0000_0000);
      wr(3'd4, 32'd0);
      wr(3'd0, ctl(8'h70, 1, 0, 1, 0));
      wait_done(2000);
      chk("R5 no cmd2", log_n, 32'd2);
      chk_log("R3 single addr", 1, 0, 1, 8'h00);
      chk("R7 status byte count", rx_n, 32'd1);
      chk("R7 status byte", {24'd0, rx_buf[0]}, {24'd0, rd_pat(0)});
      chk("R8 both flags", {30'd0, irq_cmd_done, irq_xfer_done}, 32'd3);
   endtask

   task automatic t_soft_reset();
      // flags from the previous read stay set on purpose
      log_n = 0; rx_n = 0; rd_idx = 0;
      rx_mode = 2;
      wr(3'd0, ctl(8'h90, 1, 0, 1, 0));
      repeat (60) @(negedge clk);
      chk("R10 stalled op active", {30'd0, nf_ce_n}, 32'd2);
      wr(3'd6, 32'h1);
      chk("R10 ce released", {30'd0, nf_ce_n}, 32'd3);
      chk("R10 flags cleared", {30'd0, irq_cmd_done, irq_xfer_done}, 32'd0);
      rx_mode = 0;
      prep();
      wr(3'd0, ctl(8'h70, 1, 0, 1, 0));
      wait_done(2000);
      chk("R10 recovery", {31'd0, irq_cmd_done}, 32'd1);
      chk("R10 recovery bytes", rx_n, 32'd1);
   endtask

   task automatic t_no_addr_read();
      prep();
      wr(3'd0, ctl(8'h90, 1, 0, 0, 0));
      repeat (50) @(negedge clk);
      chk("R9 no bus", log_n, 32'd0);
      chk("R9 ce idle", {30'd0, nf_ce_n}, 32'd3);
      chk("R9 no irq", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_erase_busy();
      prep();
      nf_rb = 1'b0;
      wr(3'd1, 32'h0000_01D0);
      wr(3'd2, 32'h0000_5600);
      wr(3'd3, 32'h0000_0003);
      wr(3'd0, ctl(8'h60, 0, 0, 3, 0));
      repeat (100) @(negedge clk);
      chk("R6 not done while busy", {31'd0, irq_cmd_done}, 32'd0);
      wr(3'd0, ctl(8'hFF, 0, 0, 1, 1));
      repeat (20) @(negedge clk);
      nf_rb = 1'b1;
      wait_done(200);
      chk("R6 done after ready", {31'd0, irq_cmd_done}, 32'd1);
      chk("R12 no second op", log_n, 32'd5);
      chk_log("R12 first kept", 0, 1, 0, 8'h60);
      chk_log("R3 erase a0", 1, 0, 1, 8'h00);
      chk_log("R3 erase a2", 3, 0, 1, 8'h03);
      chk_log("R5 erase cmd2", 4, 1, 0, 8'hD0);
      chk("R12 ce stayed 0", {30'd0, log_ce[4]}, 32'd2);
   endtask

   task automatic t_w1c();
      // set the transfer flag, then clear only done
      prep();
      wr(3'd0, ctl(8'h70, 1, 0, 1, 0));
      wait_done(2000);
      wr(3'd5, 32'h8000_0000);
      chk("R8 w1c done", {30'd0, irq_cmd_done, irq_xfer_done}, 32'd1);
      wr(3'd5, 32'h1000_0000);
      chk("R8 w1c xfer", {31'd0, irq_xfer_done}, 32'd0);
   endtask

   task automatic t_collision();
      prep();
      wr(3'd1, 32'h0000_01D0);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = ctl(8'h60, 0, 0, 2, 0);
      @(negedge clk);
      reg_addr = 3'd5; reg_wdata = 32'h8000_0000;
      hi_cnt = 0; cnt_en = 1;
      repeat (300) @(negedge clk);
      reg_we = 1'b0;
      cnt_en = 0;
      chk("R8 set wins over clear", hi_cnt, 32'd1);
      chk("R8 erase completed", log_n, 32'd4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_program();
      t_read_page();
      t_status();
      t_soft_reset();
      t_no_addr_read();
      t_erase_busy();
      t_w1c();
      t_collision();
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule